// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block decides, once per clock, which control-store word a microprogrammed control unit runs next. It holds the control address register, whose value goes straight out to address the external control store, and a one-deep return-address register used by microcode subroutines. Each cycle it looks at the sequencing fields of the microinstruction being executed, a two-bit condition selector, a two-bit branch kind and a seven-bit target address, and at three status inputs from the datapath: the indirect flag of the fetched instruction, the accumulator sign and an accumulator-is-zero flag. From these it picks one of four next-address sources.

The four sources are the current address plus one, the target field, the saved return address, and an address built from the four-bit opcode of the machine instruction. The opcode is placed two bits up from the bottom, so each machine instruction owns a four-word slot in the low half of the control store. The upper half holds the fetch routine, which is where the register points after reset. Storage of the microprogram and execution of its microoperations are handled elsewhere.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous active-high reset loads the control address with 64 (binary 1000000) and clears the return register to 0, so a return issued straight after reset goes to address 0.
- R2: The condition selector picks the test bit T: code 00 gives a constant 1, code 01 the indirect flag, code 10 the accumulator sign, code 11 the accumulator-zero flag.
- R3: With branch kind 00 (jump) and T=1, the next address is the target field.
- R4: With branch kind 00 (jump) and T=0, the next address is the current address plus one.
- R5: With branch kind 01 (call) and T=1, the next address is the target field and the return register takes the current address plus one.
- R6: With branch kind 01 (call) and T=0, the next address is the current address plus one and the return register keeps its value.
- R7: With branch kind 10 (return), the next address is the return register, whatever T is.
- R8: With branch kind 11 (map), the next address is the opcode placed in bits 5..2 with bits 6, 1 and 0 cleared, whatever T is; opcode 5 gives 20 and opcode 15 gives 60.
- R9: The plus-one path wraps modulo 128, so falling through from address 127 gives address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition selector of the current microinstruction |
| br_kind | input | 2 | Branch kind of the current microinstruction |
| tgt_addr | input | 7 | Target address field of the current microinstruction |
| ind_flag | input | 1 | Indirect-addressing flag of the machine instruction |
| acc_neg | input | 1 | Accumulator sign bit |
| acc_zero | input | 1 | Accumulator equals zero |
| opcode | input | 4 | Machine-instruction opcode used by the map source |
| car | output | 7 | Control address driven to the control store |

## Verification
The assertions take for granted that every input carries a known value at each rising edge and holds it through the edge, since each property compares the new address against the sampled fields and flags of the cycle before. The stimulus changes inputs only a short time after the rising edge and reads the address before the next one, so each applied microinstruction governs exactly one transition. Return behaviour is only observable through the address, so the stimulus always follows a call, a skipped call or a reset with a return to bring the saved value out.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic [1:0] {
      BR_JMP  = 2'b00,
      BR_CALL = 2'b01,
      BR_RET  = 2'b10,
      BR_MAP  = 2'b11
   } br_kind_e;

   typedef enum logic [1:0] {
      SRC_INC = 2'b00,
      SRC_SBR = 2'b01,
      SRC_TGT = 2'b10,
      SRC_MAP = 2'b11
   } src_sel_e;

   typedef enum logic [1:0] {
      CD_ALWAYS = 2'b00,
      CD_IND    = 2'b01,
      CD_NEG    = 2'b10,
      CD_ZERO   = 2'b11
   } cond_sel_e;
endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
   import useq_pkg::*;
(
   input  logic [1:0] cond_sel,
   input  logic       ind_flag,
   input  logic       acc_neg,
   input  logic       acc_zero,
   output logic       test_bit
);
   logic [3:0] cand;

   assign cand = {acc_zero, acc_neg, ind_flag, 1'b1};

   always_comb begin
      test_bit = cand[cond_sel];
   end
endmodule

// File: rtl/useq_src_decode.sv
module useq_src_decode
   import useq_pkg::*;
#(
   parameter bit USE_EQUATIONS = 1'b1
) (
   input  logic [1:0] br_kind,
   input  logic       test_bit,
   output src_sel_e   src_sel,
   output logic       sbr_load
);
   generate
      if (USE_EQUATIONS) begin : g_eqn
         logic i0, i1, s0, s1;
         assign i0 = br_kind[1];
         assign i1 = br_kind[0];
         assign s0 = i0;
         assign s1 = (i0 & i1) | (~i0 & test_bit);
         assign sbr_load = ~i0 & i1 & test_bit;
         assign src_sel = src_sel_e'({s1, s0});
      end else begin : g_case
         always_comb begin
            src_sel  = SRC_INC;
            sbr_load = 1'b0;
            unique case (br_kind_e'(br_kind))
               BR_JMP:  src_sel = test_bit ? SRC_TGT : SRC_INC;
               BR_CALL: begin
                  src_sel  = test_bit ? SRC_TGT : SRC_INC;
                  sbr_load = test_bit;
               end
               BR_RET:  src_sel = SRC_SBR;
               BR_MAP:  src_sel = SRC_MAP;
               default: src_sel = SRC_INC;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
   import useq_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int OPC_W   = 4,
   parameter int MAP_LSB = 2
) (
   input  src_sel_e            src_sel,
   input  logic [ADDR_W-1:0]   car_q,
   input  logic [ADDR_W-1:0]   sbr_q,
   input  logic [ADDR_W-1:0]   tgt_addr,
   input  logic [OPC_W-1:0]    opcode,
   output logic [ADDR_W-1:0]   inc_addr,
   output logic [ADDR_W-1:0]   nxt_addr
);
   localparam int MAP_MSB = MAP_LSB + OPC_W - 1;

   logic [ADDR_W-1:0] map_addr;

   assign inc_addr = car_q + ADDR_W'(1);

   generate
      for (genvar b = 0; b < ADDR_W; b++) begin : g_map
         if (b >= MAP_LSB && b <= MAP_MSB) begin : g_opc
            assign map_addr[b] = opcode[b - MAP_LSB];
         end else begin : g_zero
            assign map_addr[b] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      unique case (src_sel)
         SRC_INC: nxt_addr = inc_addr;
         SRC_SBR: nxt_addr = sbr_q;
         SRC_TGT: nxt_addr = tgt_addr;
         SRC_MAP: nxt_addr = map_addr;
         default: nxt_addr = inc_addr;
      endcase
   end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
   import useq_pkg::*;
#(
   parameter int ADDR_W        = 7,
   parameter int OPC_W         = 4,
   parameter int MAP_LSB       = 2,
   parameter int RESET_ADDR    = 64,
   parameter bit USE_EQUATIONS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        cond_sel,
   input  logic [1:0]        br_kind,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              ind_flag,
   input  logic              acc_neg,
   input  logic              acc_zero,
   input  logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] car
);
   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] RST_CAR = ADDR_W'(RESET_ADDR);

   generate
      if (MAP_LSB + OPC_W > ADDR_W) begin : g_bad_map
         $error("opcode field does not fit in the control address");
      end
      if (RESET_ADDR < 0 || RESET_ADDR >= ADDR_SPAN) begin : g_bad_rst
         $error("reset address outside the control store");
      end
      if (ADDR_W < 2 || OPC_W < 1) begin : g_bad_w
         $error("address or opcode width too small");
      end
   endgenerate

   logic              test_bit;
   src_sel_e          src_sel;
   logic              sbr_load;
   logic [ADDR_W-1:0] car_q;
   logic [ADDR_W-1:0] sbr_q;
   logic [ADDR_W-1:0] inc_addr;
   logic [ADDR_W-1:0] nxt_addr;

   useq_cond_sel u_cond (
      .cond_sel (cond_sel),
      .ind_flag (ind_flag),
      .acc_neg  (acc_neg),
      .acc_zero (acc_zero),
      .test_bit (test_bit)
   );

   useq_src_decode #(
      .USE_EQUATIONS (USE_EQUATIONS)
   ) u_dec (
      .br_kind  (br_kind),
      .test_bit (test_bit),
      .src_sel  (src_sel),
      .sbr_load (sbr_load)
   );

   useq_addr_mux #(
      .ADDR_W  (ADDR_W),
      .OPC_W   (OPC_W),
      .MAP_LSB (MAP_LSB)
   ) u_mux (
      .src_sel  (src_sel),
      .car_q    (car_q),
      .sbr_q    (sbr_q),
      .tgt_addr (tgt_addr),
      .opcode   (opcode),
      .inc_addr (inc_addr),
      .nxt_addr (nxt_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         car_q <= RST_CAR;
         sbr_q <= '0;
      end else begin
         car_q <= nxt_addr;
         if (sbr_load) begin
            sbr_q <= inc_addr;
         end
      end
   end

   assign car = car_q;
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
   parameter int ADDR_W     = 7,
   parameter int OPC_W      = 4,
   parameter int MAP_LSB    = 2,
   parameter int RESET_ADDR = 64
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        cond_sel,
   input logic [1:0]        br_kind,
   input logic [ADDR_W-1:0] tgt_addr,
   input logic              ind_flag,
   input logic              acc_neg,
   input logic              acc_zero,
   input logic [OPC_W-1:0]  opcode,
   input logic [ADDR_W-1:0] car,
   input logic [ADDR_W-1:0] sbr_q
);
   logic past_ok = 1'b0;
   logic t_in;
   logic [ADDR_W-1:0] map_exp;

   always_ff @(posedge clk) past_ok <= 1'b1;

   always_comb begin
      unique case (cond_sel)
         2'b00: t_in = 1'b1;
         2'b01: t_in = ind_flag;
         2'b10: t_in = acc_neg;
         default: t_in = acc_zero;
      endcase
      map_exp = ADDR_W'({opcode, MAP_LSB'(0)});
   end

   // R1
   p_reset_car_r1: assert property (@(posedge clk)
      past_ok && $past(rst) |-> car == ADDR_W'(RESET_ADDR) && sbr_q == '0);

   // R2, R3
   p_jmp_taken_r3: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(br_kind == 2'b00 && t_in) |-> car == $past(tgt_addr));

   // R2, R4
   p_jmp_fall_r4: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(br_kind == 2'b00 && !t_in) |-> car == ADDR_W'($past(car) + 1'b1));

   // R5
   p_call_taken_r5: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(br_kind == 2'b01 && t_in)
      |-> car == $past(tgt_addr) && sbr_q == ADDR_W'($past(car) + 1'b1));

   // R6
   p_call_skip_r6: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(br_kind == 2'b01 && !t_in)
      |-> $stable(sbr_q) && car == ADDR_W'($past(car) + 1'b1));

   // R7
   p_ret_r7: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(br_kind == 2'b10) |-> car == $past(sbr_q));

   // R8
   p_map_r8: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(br_kind == 2'b11) |-> car == $past(map_exp));

   // R9
   p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(car) == '1 && $past(br_kind == 2'b00 && !t_in) |-> car == '0);
endmodule

bind useq_next_addr useq_next_addr_chk #(
   .ADDR_W     (ADDR_W),
   .OPC_W      (OPC_W),
   .MAP_LSB    (MAP_LSB),
   .RESET_ADDR (RESET_ADDR)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cond_sel (cond_sel),
   .br_kind  (br_kind),
   .tgt_addr (tgt_addr),
   .ind_flag (ind_flag),
   .acc_neg  (acc_neg),
   .acc_zero (acc_zero),
   .opcode   (opcode),
   .car      (car),
   .sbr_q    (sbr_q)
);

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic [1:0] cond_sel = 2'b00;
   logic [1:0] br_kind = 2'b00;
   logic [6:0] tgt_addr = '0;
   logic       ind_flag = 1'b0;
   logic       acc_neg = 1'b0;
   logic       acc_zero = 1'b0;
   logic [3:0] opcode = '0;
   logic [6:0] car;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   useq_next_addr u_dut (
      .clk      (clk),
      .rst      (rst),
      .cond_sel (cond_sel),
      .br_kind  (br_kind),
      .tgt_addr (tgt_addr),
      .ind_flag (ind_flag),
      .acc_neg  (acc_neg),
      .acc_zero (acc_zero),
      .opcode   (opcode),
      .car      (car)
   );

   task automatic check(input logic [6:0] exp, input string tag);
      total++;
      if (car !== exp) begin
         bad++;
         $display("FAIL %s: car=%0d expected=%0d", tag, car, exp);
      end
   endtask

   // apply one microinstruction for one edge, then check the new address
   task automatic step(input logic [1:0] cd, input logic [1:0] br,
                       input logic [6:0] ad, input logic [3:0] opc,
                       input logic i, input logic s, input logic z,
                       input logic [6:0] exp, input string tag);
      cond_sel = cd; br_kind = br; tgt_addr = ad; opcode = opc;
      ind_flag = i; acc_neg = s; acc_zero = z;
      @(posedge clk); #2;
      check(exp, tag);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk); #2;
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check(7'd64, "R1 reset address");
      step(2'b00, 2'b10, 7'd99, 4'd0, 1'b0, 1'b0, 1'b0, 7'd0, "R1 return after reset");
   endtask

   task automatic t_jump();
      step(2'b00, 2'b00, 7'd5, 4'd0, 1'b0, 1'b0, 1'b0, 7'd5, "R3 R2 unconditional jump");
      step(2'b01, 2'b00, 7'd40, 4'd0, 1'b0, 1'b1, 1'b1, 7'd6, "R4 R2 indirect clear falls");
      step(2'b01, 2'b00, 7'd40, 4'd0, 1'b1, 1'b0, 1'b0, 7'd40, "R3 R2 indirect set jumps");
      step(2'b10, 2'b00, 7'd90, 4'd0, 1'b1, 1'b0, 1'b1, 7'd41, "R4 R2 sign clear falls");
      step(2'b10, 2'b00, 7'd90, 4'd0, 1'b0, 1'b1, 1'b0, 7'd90, "R3 R2 sign set jumps");
      step(2'b11, 2'b00, 7'd12, 4'd0, 1'b1, 1'b1, 1'b0, 7'd91, "R4 R2 zero clear falls");
      step(2'b11, 2'b00, 7'd12, 4'd0, 1'b0, 1'b0, 1'b1, 7'd12, "R3 R2 zero set jumps");
   endtask

   task automatic t_call();
      step(2'b00, 2'b01, 7'd67, 4'd0, 1'b0, 1'b0, 1'b0, 7'd67, "R5 call taken");
      step(2'b00, 2'b00, 7'd68, 4'd0, 1'b0, 1'b0, 1'b0, 7'd68, "R3 inside subroutine");
      step(2'b00, 2'b10, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0, 7'd13, "R5 R7 return to caller+1");
      step(2'b01, 2'b01, 7'd67, 4'd0, 1'b0, 1'b0, 1'b0, 7'd14, "R6 call skipped");
      step(2'b11, 2'b10, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0, 7'd13, "R6 R7 saved return kept");
   endtask

   task automatic t_map();
      step(2'b01, 2'b11, 7'd100, 4'd5, 1'b0, 1'b0, 1'b0, 7'd20, "R8 map opcode 5");
      step(2'b00, 2'b11, 7'd100, 4'd15, 1'b0, 1'b0, 1'b0, 7'd60, "R8 map opcode 15");
      step(2'b11, 2'b11, 7'd100, 4'd0, 1'b0, 1'b0, 1'b0, 7'd0, "R8 map opcode 0");
   endtask

   task automatic t_wrap();
      step(2'b00, 2'b00, 7'd127, 4'd0, 1'b0, 1'b0, 1'b0, 7'd127, "R3 jump to top");
      step(2'b10, 2'b00, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0, 7'd0, "R9 wrap to zero");
      step(2'b00, 2'b00, 7'd127, 4'd0, 1'b0, 1'b0, 1'b0, 7'd127, "R3 jump to top again");
      step(2'b10, 2'b01, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0, 7'd0, "R9 R6 skipped call wraps");
      step(2'b00, 2'b10, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0, 7'd13, "R6 return unchanged after wrap");
      do_reset();
      check(7'd64, "R1 reset after activity");
      step(2'b01, 2'b10, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0, 7'd0, "R1 R7 return register cleared");
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: car=%0d expected=finish", car);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_jump();
      t_call();
      t_map();
      t_wrap();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule